// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block lays a small two-plane cursor image over a scanned-out frame. Software loads a 32-row mask plane, a 32-row image plane and a cursor origin through a word-addressed register window. During scan-out the video pipeline presents one pixel per cycle: its x and y coordinates, the current active width and height, and the underlying palette index or colour. One cycle later the engine returns a select code. The code tells the colour stage to keep the underlying pixel or to replace it with one of two overlay colours, 258 or 259. The underlying pixel value is delayed alongside the code.

Each cursor row is one word in each plane. The left-most cursor column takes the most significant bit. A clear mask bit lets the frame show through. A set mask bit paints the pixel, and the matching image bit picks which of the two overlay colours is used. The cursor is cut off at the right edge of the active area. It vanishes entirely when its origin lies at or beyond the active width. After reset the origin sits far to the right, so nothing is painted until software moves the cursor.

The same window also holds a general status word. That word always reads back with one flag bit set. No other location can be read.

Top module: `curs_overlay`

## Requirements
- R1: After reset, out_valid, out_sel, out_pix and reg_rdata are zero. The cursor origin is x = 0xF000, y = 0, so no pixel of a screen narrower than 0xF000 is replaced. Both planes and the status word are cleared.
- R2: A write to offset 0x8FC sets the cursor origin: x from wdata bits 31:16 and y from wdata bits 15:0.
- R3: Writes to offsets 0x900..0x97F load mask row (offset-0x900)>>2. Writes to offsets 0x980..0x9FF load image row (offset-0x980)>>2. Unaligned offsets inside a range select the row by the same formula.
- R4: Cursor column c (c = x - cursor x) uses bit 31-c of the row word, in both planes.
- R5: The out_sel code is 2'b11 (overlay colour 259) when the mask bit is 1 and the image bit is 1. It is 2'b10 (colour 258) when the mask bit is 1 and the image bit is 0. It is 2'b00 (pass through) when the mask bit is 0, when the pixel is outside the cursor, or when no pixel was presented. Code 2'b01 never appears.
- R6: A pixel is inside the cursor vertically only when cursor y <= y < cursor y + 32. This bound is computed without wrap-around, so a cursor near the bottom of the coordinate range never reaches rows near 0.
- R7: Horizontally the cursor applies only when cursor x < active width. It then covers x from cursor x up to but excluding cursor x + min(width - cursor x, 32).
- R8: Pixels with x >= active width or y >= active height always pass through.
- R9: out_valid, out_sel and out_pix follow pix_valid, the select decision and pix_in with exactly one cycle of latency.
- R10: A write to offset 0x818 stores a 32-bit status word. A read of 0x818 returns it with bit 25 forced to 1. Read data appears on reg_rdata in the cycle after reg_rd_en and holds until the next read.
- R11: Reads of any offset other than 0x818 return zero, including the position and plane offsets. Writes to unmapped offsets (e.g. 0x8F8, 0xA00) change no cursor state.
- R12: A register write and a pixel presented in the same cycle: the pixel is judged against the state that existed before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (12) | Byte offset into the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd_en |
| pix_valid | input | 1 | A scan pixel is presented this cycle |
| pix_x | input | COORD_W (16) | Scan pixel column |
| pix_y | input | COORD_W (16) | Scan pixel row |
| act_width | input | COORD_W (16) | Active display width |
| act_height | input | COORD_W (16) | Active display height |
| pix_in | input | PIX_W (8) | Underlying palette index or colour |
| out_valid | output | 1 | Delayed pix_valid |
| out_sel | output | 2 | Colour select: 00 pass, 10 colour 258, 11 colour 259 |
| out_pix | output | PIX_W (8) | Delayed underlying pixel |

## Verification
The hardest states to reach are those where the cursor geometry meets its limits. These are a cursor cut by the right edge, an origin at or past the active width, and an origin within 32 rows of the top of the coordinate range, where a wrapped comparison would wrongly paint rows near zero. The stimulus reaches them by rewriting the origin and the active width and height between single probe pixels. The plane rows are loaded with patterns whose set bits sit at known columns, so each probe has a single correct code. Some probes are placed so that an off-by-one or a reversed bit order gives a different code. A same-cycle write-and-probe and writes to offsets just outside each range cover the decode boundaries. A random phase then runs against the behavioural model.

// File: rtl/curs_ovl_pkg.sv
package curs_ovl_pkg;

   localparam int REG_W = 32;

   // Overlay select encoding: bit 1 = painted, bit 0 = which overlay colour
   typedef enum logic [1:0] {
      SEL_PASS    = 2'b00,
      SEL_COLOR_A = 2'b10,   // overlay colour 258
      SEL_COLOR_B = 2'b11    // overlay colour 259
   } ovl_sel_e;

   function automatic ovl_sel_e plane_code(input logic mask_bit, input logic img_bit);
      if (!mask_bit)
         return SEL_PASS;
      else if (img_bit)
         return SEL_COLOR_B;
      else
         return SEL_COLOR_A;
   endfunction

endpackage

// File: rtl/curs_regbank.sv
module curs_regbank
   import curs_ovl_pkg::*;
#(
   parameter int                ADDR_W    = 12,
   parameter int                COORD_W   = 16,
   parameter int                CUR_DIM   = 32,
   parameter logic [ADDR_W-1:0] POS_OFS   = 12'h8FC,
   parameter logic [ADDR_W-1:0] MASK_BASE = 12'h900,
   parameter logic [ADDR_W-1:0] IMG_BASE  = 12'h980,
   parameter logic [ADDR_W-1:0] STAT_OFS  = 12'h818,
   parameter int                FORCE_BIT = 25,
   parameter logic [COORD_W-1:0] RESET_X  = 16'hF000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [REG_W-1:0]    wdata,
   output logic [REG_W-1:0]    rdata,
   output logic [COORD_W-1:0]  cur_x,
   output logic [COORD_W-1:0]  cur_y,
   output logic [CUR_DIM-1:0]  mask_rows [CUR_DIM],
   output logic [CUR_DIM-1:0]  img_rows  [CUR_DIM]
);

   localparam int                ROW_W      = $clog2(CUR_DIM);
   localparam int                SPAN       = 4 * CUR_DIM;
   localparam logic [ADDR_W:0]   MASK_END   = {1'b0, MASK_BASE} + (ADDR_W+1)'(SPAN);
   localparam logic [ADDR_W:0]   IMG_END    = {1'b0, IMG_BASE} + (ADDR_W+1)'(SPAN);
   localparam logic [REG_W-1:0]  FORCE_MASK = REG_W'(1) << FORCE_BIT;

   logic [ADDR_W:0]    addr_x;
   logic               in_mask, in_img;
   logic [ROW_W-1:0]   mask_row, img_row;
   logic [CUR_DIM-1:0] mask_we, img_we;
   logic [REG_W-1:0]   stat_q;

   assign addr_x   = {1'b0, addr};
   assign in_mask  = (addr_x >= {1'b0, MASK_BASE}) && (addr_x < MASK_END);
   assign in_img   = (addr_x >= {1'b0, IMG_BASE})  && (addr_x < IMG_END);
   assign mask_row = ROW_W'((addr - MASK_BASE) >> 2);
   assign img_row  = ROW_W'((addr - IMG_BASE) >> 2);

   // per-row write enables
   for (genvar r = 0; r < CUR_DIM; r++) begin : g_row_we
      assign mask_we[r] = wr_en && in_mask && (mask_row == ROW_W'(r));
      assign img_we[r]  = wr_en && in_img  && (img_row  == ROW_W'(r));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < CUR_DIM; r++) begin
            mask_rows[r] <= '0;
            img_rows[r]  <= '0;
         end
      end else begin
         for (int r = 0; r < CUR_DIM; r++) begin
            if (mask_we[r]) mask_rows[r] <= wdata[CUR_DIM-1:0];
            if (img_we[r])  img_rows[r]  <= wdata[CUR_DIM-1:0];
         end
      end
   end

   // cursor origin: x in the upper half-word, y in the lower
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_x <= RESET_X;
         cur_y <= '0;
      end else if (wr_en && (addr == POS_OFS)) begin
         cur_x <= wdata[16 +: COORD_W];
         cur_y <= wdata[COORD_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= '0;
      else if (wr_en && (addr == STAT_OFS))
         stat_q <= wdata;
   end

   // registered read port: only the status word is visible
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= (addr == STAT_OFS) ? (stat_q | FORCE_MASK) : '0;
   end

endmodule

// File: rtl/curs_window.sv
module curs_window #(
   parameter int COORD_W = 16,
   parameter int CUR_DIM = 32,
   localparam int ROW_W  = $clog2(CUR_DIM)
) (
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [COORD_W-1:0] act_w,
   input  logic [COORD_W-1:0] act_h,
   input  logic [COORD_W-1:0] cur_x,
   input  logic [COORD_W-1:0] cur_y,
   output logic               hit,
   output logic [ROW_W-1:0]   row,
   output logic [ROW_W-1:0]   col
);

   localparam logic [COORD_W:0] DIM_X = (COORD_W+1)'(CUR_DIM);

   logic [COORD_W:0] px, py, w, h, cx, cy;
   logic             in_active, x_on, in_rows, in_cols;

   // one extra bit keeps cursor + DIM from wrapping
   assign px = {1'b0, pix_x};
   assign py = {1'b0, pix_y};
   assign w  = {1'b0, act_w};
   assign h  = {1'b0, act_h};
   assign cx = {1'b0, cur_x};
   assign cy = {1'b0, cur_y};

   assign in_active = (px < w) && (py < h);
   assign x_on      = (cx < w);
   assign in_rows   = (py >= cy) && (py < cy + DIM_X);
   // px < w (in in_active) provides the right-edge clip
   assign in_cols   = (px >= cx) && (px < cx + DIM_X);

   assign hit = in_active && x_on && in_rows && in_cols;
   assign row = ROW_W'(pix_y - cur_y);
   assign col = ROW_W'(pix_x - cur_x);

endmodule

// File: rtl/curs_planesel.sv
module curs_planesel
   import curs_ovl_pkg::*;
#(
   parameter int CUR_DIM = 32,
   localparam int ROW_W  = $clog2(CUR_DIM)
) (
   input  logic                hit,
   input  logic [ROW_W-1:0]    row,
   input  logic [ROW_W-1:0]    col,
   input  logic [CUR_DIM-1:0]  mask_rows [CUR_DIM],
   input  logic [CUR_DIM-1:0]  img_rows  [CUR_DIM],
   output ovl_sel_e            sel
);

   logic [ROW_W-1:0]   bit_idx;
   logic [CUR_DIM-1:0] mask_word, img_word;

   // leftmost column maps to the most significant bit
   assign bit_idx   = ROW_W'(CUR_DIM - 1) - col;
   assign mask_word = mask_rows[row];
   assign img_word  = img_rows[row];

   always_comb begin
      if (hit)
         sel = plane_code(mask_word[bit_idx], img_word[bit_idx]);
      else
         sel = SEL_PASS;
   end

endmodule

// File: rtl/curs_overlay.sv
module curs_overlay
   import curs_ovl_pkg::*;
#(
   parameter int                 ADDR_W    = 12,
   parameter int                 COORD_W   = 16,
   parameter int                 PIX_W     = 8,
   parameter int                 CUR_DIM   = 32,
   parameter logic [ADDR_W-1:0]  POS_OFS   = 12'h8FC,
   parameter logic [ADDR_W-1:0]  MASK_BASE = 12'h900,
   parameter logic [ADDR_W-1:0]  IMG_BASE  = 12'h980,
   parameter logic [ADDR_W-1:0]  STAT_OFS  = 12'h818,
   parameter int                 FORCE_BIT = 25,
   parameter logic [COORD_W-1:0] RESET_X   = 16'hF000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr_en,
   input  logic               reg_rd_en,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               pix_valid,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [COORD_W-1:0] act_width,
   input  logic [COORD_W-1:0] act_height,
   input  logic [PIX_W-1:0]   pix_in,
   output logic               out_valid,
   output logic [1:0]         out_sel,
   output logic [PIX_W-1:0]   out_pix
);

   localparam int ROW_W = $clog2(CUR_DIM);

   // elaboration-time parameter checks
   if (CUR_DIM < 2 || CUR_DIM > REG_W || (1 << ROW_W) != CUR_DIM) begin : g_bad_dim
      $error("CUR_DIM must be a power of two between 2 and 32");
   end
   if (COORD_W < ROW_W || COORD_W > 16) begin : g_bad_coord
      $error("COORD_W must lie between log2(CUR_DIM) and 16");
   end
   if (FORCE_BIT < 0 || FORCE_BIT >= REG_W) begin : g_bad_force
      $error("FORCE_BIT outside the register word");
   end
   if (int'(MASK_BASE) + 4*CUR_DIM > int'(IMG_BASE) && int'(IMG_BASE) + 4*CUR_DIM > int'(MASK_BASE)) begin : g_overlap
      $error("mask and image ranges overlap");
   end

   logic [COORD_W-1:0] cur_x, cur_y;
   logic [CUR_DIM-1:0] mask_rows [CUR_DIM];
   logic [CUR_DIM-1:0] img_rows  [CUR_DIM];
   logic               hit;
   logic [ROW_W-1:0]   row, col;
   ovl_sel_e           sel;

   curs_regbank #(
      .ADDR_W(ADDR_W), .COORD_W(COORD_W), .CUR_DIM(CUR_DIM),
      .POS_OFS(POS_OFS), .MASK_BASE(MASK_BASE), .IMG_BASE(IMG_BASE),
      .STAT_OFS(STAT_OFS), .FORCE_BIT(FORCE_BIT), .RESET_X(RESET_X)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .cur_x(cur_x), .cur_y(cur_y),
      .mask_rows(mask_rows), .img_rows(img_rows)
   );

   curs_window #(.COORD_W(COORD_W), .CUR_DIM(CUR_DIM)) win_i (
      .pix_x(pix_x), .pix_y(pix_y),
      .act_w(act_width), .act_h(act_height),
      .cur_x(cur_x), .cur_y(cur_y),
      .hit(hit), .row(row), .col(col)
   );

   curs_planesel #(.CUR_DIM(CUR_DIM)) sel_i (
      .hit(hit), .row(row), .col(col),
      .mask_rows(mask_rows), .img_rows(img_rows),
      .sel(sel)
   );

   // single output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sel   <= SEL_PASS;
         out_pix   <= '0;
      end else begin
         out_valid <= pix_valid;
         out_sel   <= pix_valid ? sel : SEL_PASS;
         out_pix   <= pix_in;
      end
   end

endmodule

// File: rtl/curs_overlay_chk.sv
module curs_overlay_chk #(
   parameter int                ADDR_W   = 12,
   parameter int                COORD_W  = 16,
   parameter int                PIX_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_OFS = 12'h818,
   parameter int                FORCE_BIT = 25
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_rd_en,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [31:0]        reg_rdata,
   input logic               pix_valid,
   input logic [COORD_W-1:0] pix_x,
   input logic [COORD_W-1:0] pix_y,
   input logic [COORD_W-1:0] act_width,
   input logic [COORD_W-1:0] act_height,
   input logic [PIX_W-1:0]   pix_in,
   input logic               out_valid,
   input logic [1:0]         out_sel,
   input logic [PIX_W-1:0]   out_pix
);

   assert_valid_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid);

   assert_valid_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !out_valid);

   assert_pix_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> (out_pix == $past(pix_in)));

   assert_idle_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_sel == 2'b00));

   assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_sel != 2'b01);

   assert_offscreen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && ((pix_x >= act_width) || (pix_y >= act_height))) |=> (out_sel == 2'b00));

   assert_status_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && (reg_addr == STAT_OFS)) |=> reg_rdata[FORCE_BIT]);

   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_en |=> $stable(reg_rdata));

   assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && (reg_addr != STAT_OFS)) |=> (reg_rdata == 32'h0));

endmodule

bind curs_overlay curs_overlay_chk #(
   .ADDR_W(ADDR_W), .COORD_W(COORD_W), .PIX_W(PIX_W),
   .STAT_OFS(STAT_OFS), .FORCE_BIT(FORCE_BIT)
) chk_i (
   .clk(clk), .rst_n(rst_n),
   .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
   .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
   .act_width(act_width), .act_height(act_height), .pix_in(pix_in),
   .out_valid(out_valid), .out_sel(out_sel), .out_pix(out_pix)
);

// File: tb/curs_overlay_tb_top.sv
module curs_overlay_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr_en, reg_rd_en;
   logic [11:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        pix_valid;
   logic [15:0] pix_x, pix_y, act_width, act_height;
   logic [7:0]  pix_in;
   logic        out_valid;
   logic [1:0]  out_sel;
   logic [7:0]  out_pix;

   always #5 clk = ~clk;

   curs_overlay dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
      .act_width(act_width), .act_height(act_height), .pix_in(pix_in),
      .out_valid(out_valid), .out_sel(out_sel), .out_pix(out_pix)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          m_cx, m_cy;
   logic [31:0] m_mask [32];
   logic [31:0] m_img  [32];
   logic [31:0] m_stat;
   logic        e_valid;
   logic [1:0]  e_sel;
   logic [7:0]  e_pix;
   logic [31:0] e_rdata;
   bit          live = 0;

   function automatic logic [1:0] ref_sel(int px, int py, int w, int h);
      int len, r, c;
      if (px >= w || py >= h) return 2'b00;
      if (m_cx >= w) return 2'b00;
      if (py < m_cy || py >= m_cy + 32) return 2'b00;
      len = (w - m_cx < 32) ? (w - m_cx) : 32;
      if (px < m_cx || px >= m_cx + len) return 2'b00;
      r = py - m_cy;
      c = px - m_cx;
      if (!m_mask[r][31-c]) return 2'b00;
      return m_img[r][31-c] ? 2'b11 : 2'b10;
   endfunction

   always @(posedge clk) begin
      int a;
      if (!rst_n) begin
         m_cx = 'hF000; m_cy = 0; m_stat = 0;
         for (int i = 0; i < 32; i++) begin m_mask[i] = 0; m_img[i] = 0; end
         e_valid = 0; e_sel = 0; e_pix = 0; e_rdata = 0;
      end else begin
         e_valid = pix_valid;
         e_sel   = pix_valid ? ref_sel(int'(pix_x), int'(pix_y), int'(act_width), int'(act_height)) : 2'b00;
         e_pix   = pix_in;
         if (reg_rd_en)
            e_rdata = (reg_addr == 12'h818) ? (m_stat | 32'h0200_0000) : 32'h0;
         if (reg_wr_en) begin
            a = int'(reg_addr);
            if (a == 'h8FC) begin
               m_cx = int'(reg_wdata[31:16]);
               m_cy = int'(reg_wdata[15:0]);
            end else if (a >= 'h900 && a < 'h980) m_mask[(a - 'h900) >> 2] = reg_wdata;
            else if (a >= 'h980 && a < 'hA00)     m_img[(a - 'h980) >> 2]  = reg_wdata;
            else if (a == 'h818)                  m_stat = reg_wdata;
         end
      end
      live = 1;
   end

   always @(negedge clk) begin
      if (live && !done) begin
         chk("R9 valid", 32'(out_valid), 32'(e_valid));
         chk("R5 select", 32'(out_sel), 32'(e_sel));
         chk("R9 pixel", 32'(out_pix), 32'(e_pix));
         chk("R10 rdata", reg_rdata, e_rdata);
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 0;
   endtask

   task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      reg_rd_en = 1; reg_addr = a;
      @(negedge clk);
      reg_rd_en = 0;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic px(int x, int y, logic [1:0] exp, string tag);
      @(negedge clk);
      pix_valid = 1; pix_x = 16'(x); pix_y = 16'(y); pix_in = 8'($urandom);
      @(negedge clk);
      pix_valid = 0;
      chk(tag, 32'(out_sel), 32'(exp));
   endtask

   task automatic set_area(int w, int h);
      @(negedge clk);
      act_width = 16'(w); act_height = 16'(h);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 0; reg_wr_en = 0; reg_rd_en = 0; reg_addr = 0; reg_wdata = 0;
      pix_valid = 0; pix_x = 0; pix_y = 0; pix_in = 0;
      act_width = 640; act_height = 480;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 out_valid", 32'(out_valid), 0);
      chk("R1 out_sel", 32'(out_sel), 0);
      chk("R1 out_pix", 32'(out_pix), 0);
      chk("R1 rdata", reg_rdata, 0);
      rd(12'h818, 32'h0200_0000, "R1 status reset");

      wr(12'h900, 32'h8000_0001);
      wr(12'h980, 32'h8000_0000);
      wr(12'h97C, 32'hFFFF_FFFF);
      wr(12'h9FC, 32'h0000_FFFF);
      px(0, 0, 2'b00, "R1 cursor off screen");

      // R2 origin, R4/R5 bit order and codes
      wr(12'h8FC, {16'd100, 16'd50});
      px(100, 50, 2'b11, "R5 mask1 img1");
      px(131, 50, 2'b10, "R4 last column bit0");
      px(101, 50, 2'b00, "R4 mask clear");
      px(99, 50, 2'b00, "R7 left of cursor");
      px(132, 50, 2'b00, "R7 right of cursor");
      px(100, 81, 2'b10, "R3 row31 col0");
      px(131, 81, 2'b11, "R3 row31 col31");
      px(115, 81, 2'b10, "R4 col15 bit16");
      px(116, 81, 2'b11, "R4 col16 bit15");
      px(100, 82, 2'b00, "R6 below cursor");
      px(100, 49, 2'b00, "R6 above cursor");
      wr(12'h907, 32'h4000_0000);
      px(101, 51, 2'b10, "R3 unaligned row1");

      // R7 right-edge clipping
      set_area(120, 480);
      px(119, 81, 2'b11, "R7 last visible col");
      px(120, 81, 2'b00, "R7 clipped col");
      set_area(100, 480);
      px(100, 50, 2'b00, "R7 origin at width");
      set_area(640, 480);

      // R8 height limit
      wr(12'h928, 32'hFFFF_FFFF);
      set_area(640, 61);
      px(100, 60, 2'b10, "R8 last active row");
      set_area(640, 60);
      px(100, 60, 2'b00, "R8 beyond height");
      set_area(640, 480);

      // R11 unmapped reads and writes
      rd(12'h8FC, 32'h0, "R11 position read");
      rd(12'h900, 32'h0, "R11 mask read");
      rd(12'h000, 32'h0, "R11 zero offset read");
      wr(12'h8F8, 32'h0);
      wr(12'hA00, 32'h0);
      wr(12'h81C, 32'h0);
      px(100, 50, 2'b11, "R11 origin and row0 kept");
      px(131, 81, 2'b11, "R11 row31 kept");

      // R10 status word
      wr(12'h818, 32'h0000_00A5);
      rd(12'h818, 32'h0200_00A5, "R10 forced flag");
      wr(12'h818, 32'hFFFF_FFFF);
      rd(12'h818, 32'hFFFF_FFFF, "R10 all ones");
      @(negedge clk);
      chk("R10 rdata held", reg_rdata, 32'hFFFF_FFFF);

      // R12 write and pixel in the same cycle
      @(negedge clk);
      reg_wr_en = 1; reg_addr = 12'h8FC; reg_wdata = {16'd500, 16'd50};
      pix_valid = 1; pix_x = 100; pix_y = 50; pix_in = 8'h3C;
      @(negedge clk);
      reg_wr_en = 0; pix_valid = 0;
      chk("R12 old origin used", 32'(out_sel), 32'b11);
      chk("R9 pixel delayed", 32'(out_pix), 32'h3C);
      px(100, 50, 2'b00, "R12 origin moved");
      px(500, 50, 2'b11, "R2 new x");
      wr(12'h8FC, {16'd10, 16'd300});
      px(10, 300, 2'b11, "R2 y field");
      px(10, 299, 2'b00, "R2 y field above");

      // R6 no wrap near the top of coordinate range
      set_area(640, 16'hFFFF);
      wr(12'h954, 32'hFFFF_FFFF);
      wr(12'h8FC, {16'd0, 16'hFFF0});
      px(0, 'hFFF0, 2'b11, "R6 high origin row0");
      px(0, 5, 2'b00, "R6 no wrap to low rows");
      for (int x = 0; x < 40; x++) begin
         @(negedge clk);
         pix_valid = 1; pix_x = 16'(x); pix_y = 16'hFFF5; pix_in = 8'($urandom);
      end
      @(negedge clk);
      pix_valid = 0;
      @(negedge clk);
      chk("R9 idle valid", 32'(out_valid), 0);

      // random phase against the model
      set_area(640, 480);
      wr(12'h8FC, {16'd80, 16'd20});
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         pix_valid = 1'($urandom);
         pix_x = 16'($urandom_range(0, 700));
         pix_y = 16'($urandom_range(0, 70));
         pix_in = 8'($urandom);
         reg_wr_en = ($urandom_range(0, 7) == 0);
         reg_rd_en = ($urandom_range(0, 7) == 0);
         reg_addr = 12'($urandom_range(12'h8F0, 12'hA08));
         reg_wdata = $urandom;
         if (reg_wr_en && reg_addr == 12'h8FC) reg_wdata = {16'($urandom_range(0, 660)), 16'($urandom_range(0, 60))};
         if ($urandom_range(0, 50) == 0) act_width = 16'($urandom_range(50, 700));
      end
      @(negedge clk);
      reg_wr_en = 0; reg_rd_en = 0; pix_valid = 0;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule